// File: doc/BRIEF.md
# USB Low-Speed Serial Transmitter

This block turns a short byte stream into a low-speed USB packet on the D+ and D- lines, with an output enable that marks when it owns the bus. It drives idle J with the drivers off, then turns them on, sends the sync byte and the packet bytes LSB first with NRZI coding and bit stuffing, and ends with a timed end-of-packet: SE0, then J, then it drops the enable. Each line state, stuffed bits included, lasts 11 clocks.

A packet starts on a one-cycle `start` request. For a data packet the host logic gives a byte count that includes the sync byte, and the block pulls the remaining bytes through a ready/valid port, holding at most one byte ahead. A handshake request instead sends sync plus an ACK or NAK identifier with no data fetched. When a data packet ends without a shortfall, the pending device address is copied, shifted left by one, into the active address output. Handshakes never update it.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset dp, dm, oe, busy, done, underrun and data_ready are 0 and dev_addr is 0.
- R2: A packet starts with one cycle of J ({dp,dm}=01) with oe low, then one cycle of J with oe high, before the first sync bit.
- R3: The first byte sent is the sync byte 0x80; every byte goes out LSB first; byte_count counts the sync byte and is clamped to the range 2 to 12.
- R4: NRZI: a 0 bit toggles the line between J (dp=0, dm=1) and K (dp=1, dm=0); a 1 bit holds it.
- R5: After six 1 bits in a row a toggle is inserted; the run count carries across byte boundaries and a stuffed bit is still sent after the last data bit.
- R6: Every bit period, stuffed bits included, lasts 11 clocks.
- R7: With hs_req high at start, exactly two bytes go out: 0x80 then 0xD2 (hs_nak=0) or 0x5A (hs_nak=1), and data_ready stays low.
- R8: The packet ends with 22 clocks of SE0 (00), then 11 clocks of J, then oe low with dp=dm=0 and done high for exactly one cycle.
- R9: busy is high in exactly the cycles in which oe is high.
- R10: A data byte is taken at a rising edge where data_ready and data_valid are both high; bytes are sent in the order taken.
- R11: If a byte is needed and none has been taken, the packet ends with the normal end-of-packet after the bits already sent and underrun goes high until the next start.
- R12: On release after a data packet without underrun, dev_addr becomes {new_addr,1'b0}; after a handshake or an underrun it keeps its value, and it changes at no other time.
- R13: start is ignored while a packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 11 cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle packet request, taken only when idle |
| hs_req | input | 1 | Send a handshake instead of a data packet |
| hs_nak | input | 1 | Handshake kind: 0 ACK, 1 NAK |
| byte_count | input | 4 | Bytes in a data packet, sync included |
| data_valid | input | 1 | Data byte offered |
| data_in | input | 8 | Data byte |
| data_ready | output | 1 | Block can take a data byte |
| new_addr | input | 7 | Pending device address |
| dev_addr | output | 8 | Active device address, left-shifted by one |
| dp | output | 1 | D+ drive value |
| dm | output | 1 | D- drive value |
| oe | output | 1 | Line driver enable |
| busy | output | 1 | High while the bus is held |
| done | output | 1 | One-cycle pulse at bus release |
| underrun | output | 1 | Last packet ran short of data |

## Verification
On every cycle the assertions check that the enable only rises onto J and only falls from J together with the done pulse, that both lines are never high together, that done lasts one cycle, and that the active address moves only at a release. The exact bit stream (sync, NRZI levels, stuffed bits at byte boundaries and at the packet end, 11-clock periods and end-of-packet lengths) can only be shown by the bench's scenarios, which rebuild the expected line trace per packet and compare it clock by clock. Underrun cut-off, handshake PIDs, byte-count clamping, ignored mid-packet requests and the choice of when the address is committed are also scenario checks.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ACQ,
        ST_TX,
        ST_EOP0,
        ST_EOPJ
    } tx_state_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_t;

    localparam line_t LINE_J   = '{dp: 1'b0, dm: 1'b1};
    localparam line_t LINE_SE0 = '{dp: 1'b0, dm: 1'b0};

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/usb_tx_clkdiv.sv
module usb_tx_clkdiv #(
    parameter int MAX_CNT = 22,
    localparam int CW = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = restart ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/usb_tx_stuffer.sv
module usb_tx_stuffer
    import usb_tx_pkg::*;
#(
    parameter int RUN    = 6,
    parameter int ONES_W = $clog2(RUN + 1)
) (
    input  line_t             cur,
    input  logic [ONES_W-1:0] ones,
    input  logic              bit_val,
    output logic              stuff,
    output line_t             nxt,
    output logic [ONES_W-1:0] ones_nxt
);

    line_t flipped;

    always_comb begin
        flipped  = '{dp: ~cur.dp, dm: ~cur.dm};
        stuff    = (ones == ONES_W'(RUN));
        if (stuff || !bit_val) begin
            nxt      = flipped;
            ones_nxt = '0;
        end else begin
            nxt      = cur;
            ones_nxt = ones + 1'b1;
        end
    end

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usb_tx_pkg::*;
#(
    parameter int BIT_CLKS  = 11,
    parameter int EOP_CLKS  = 22,
    parameter int MAX_BYTES = 12,
    parameter int STUFF_RUN = 6,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hs_req,
    input  logic             hs_nak,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             data_valid,
    input  logic [7:0]       data_in,
    output logic             data_ready,
    input  logic [6:0]       new_addr,
    output logic [7:0]       dev_addr,
    output logic             dp,
    output logic             dm,
    output logic             oe,
    output logic             busy,
    output logic             done,
    output logic             underrun
);

    localparam int DIV_MAX = (BIT_CLKS > EOP_CLKS) ? BIT_CLKS : EOP_CLKS;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);
    localparam int ONES_W  = $clog2(STUFF_RUN + 1);

    typedef struct packed {
        tx_state_e         st;
        line_t             line;
        logic              oe;
        logic [7:0]        sh;
        logic [3:0]        bidx;
        logic [ONES_W-1:0] ones;
        logic [CNT_W-1:0]  bytes_left;
        logic [CNT_W-1:0]  fetch_left;
        logic [7:0]        nxt;
        logic              nxt_full;
        logic              is_hs;
        logic              underrun;
        logic              done;
        logic [7:0]        addr;
    } regs_t;

    regs_t r_q, r_d;

    logic [DIV_W-1:0]  div_cnt;
    logic              restart;
    logic              bnd;
    logic              need_load;
    logic [7:0]        eff;
    logic              stuff;
    line_t             st_line;
    logic [ONES_W-1:0] st_ones;
    logic [CNT_W-1:0]  cnt_c;

    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] c);
        if (c < CNT_W'(2))              return CNT_W'(2);
        else if (c > CNT_W'(MAX_BYTES)) return CNT_W'(MAX_BYTES);
        else                            return c;
    endfunction

    usb_tx_clkdiv #(.MAX_CNT(DIV_MAX)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt     (div_cnt)
    );

    usb_tx_stuffer #(.RUN(STUFF_RUN), .ONES_W(ONES_W)) u_stuff (
        .cur      (r_q.line),
        .ones     (r_q.ones),
        .bit_val  (eff[0]),
        .stuff    (stuff),
        .nxt      (st_line),
        .ones_nxt (st_ones)
    );

    assign data_ready = (r_q.st == ST_PREP || r_q.st == ST_ACQ || r_q.st == ST_TX)
                        && !r_q.nxt_full && (r_q.fetch_left != '0);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        bnd       = (r_q.st == ST_ACQ) ||
                    (r_q.st == ST_TX && div_cnt == DIV_W'(BIT_CLKS - 1));
        need_load = (r_q.bidx == 4'd8);
        eff       = need_load ? r_q.nxt : r_q.sh;
        cnt_c     = clamp_count(byte_count);

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st         = ST_PREP;
                    r_d.line       = LINE_J;
                    r_d.is_hs      = hs_req;
                    r_d.sh         = SYNC_BYTE;
                    r_d.bidx       = '0;
                    r_d.ones       = '0;
                    r_d.underrun   = 1'b0;
                    r_d.bytes_left = hs_req ? CNT_W'(1) : cnt_c - 1'b1;
                    r_d.fetch_left = hs_req ? '0 : cnt_c - 1'b1;
                    r_d.nxt        = hs_req ? (hs_nak ? PID_NAK : PID_ACK) : 8'h00;
                    r_d.nxt_full   = hs_req;
                end
            end
            ST_PREP: begin
                r_d.st = ST_ACQ;
                r_d.oe = 1'b1;
            end
            ST_ACQ, ST_TX: begin
                if (bnd) begin
                    if (stuff) begin
                        r_d.st   = ST_TX;
                        r_d.line = st_line;
                        r_d.ones = st_ones;
                    end else if (need_load && (r_q.bytes_left == '0 || !r_q.nxt_full)) begin
                        r_d.st       = ST_EOP0;
                        r_d.line     = LINE_SE0;
                        r_d.underrun = (r_q.bytes_left != '0);
                    end else begin
                        r_d.st   = ST_TX;
                        r_d.line = st_line;
                        r_d.ones = st_ones;
                        r_d.sh   = {1'b0, eff[7:1]};
                        r_d.bidx = need_load ? 4'd1 : r_q.bidx + 4'd1;
                        if (need_load) begin
                            r_d.bytes_left = r_q.bytes_left - 1'b1;
                            r_d.nxt_full   = 1'b0;
                        end
                    end
                end
            end
            ST_EOP0: begin
                if (div_cnt == DIV_W'(EOP_CLKS - 1)) begin
                    r_d.st   = ST_EOPJ;
                    r_d.line = LINE_J;
                end
            end
            ST_EOPJ: begin
                if (div_cnt == DIV_W'(BIT_CLKS - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.oe   = 1'b0;
                    r_d.line = LINE_SE0;
                    r_d.done = 1'b1;
                    if (!r_q.is_hs && !r_q.underrun) r_d.addr = {new_addr, 1'b0};
                end
            end
            default: r_d = r_q;
        endcase

        if (data_ready && data_valid) begin
            r_d.nxt        = data_in;
            r_d.nxt_full   = 1'b1;
            r_d.fetch_left = r_q.fetch_left - 1'b1;
        end

        restart = bnd || (r_d.st != r_q.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dp       = r_q.line.dp;
    assign dm       = r_q.line.dm;
    assign oe       = r_q.oe;
    assign busy     = r_q.oe;
    assign done     = r_q.done;
    assign underrun = r_q.underrun;
    assign dev_addr = r_q.addr;

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dp,
    input logic       dm,
    input logic       oe,
    input logic       done,
    input logic [7:0] dev_addr
);

    // R2: drivers switch on only onto idle J
    a_r2_acquire_in_j: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (!dp && dm));

    // R8: drivers switch off only after J, together with done and quiet lines
    a_r8_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> ($past(dm) && !$past(dp) && done && !dp && !dm));

    // R8: done is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the line is J, K or SE0, never both high
    a_r4_no_se1: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp && dm));

    // R12: the active address moves only at a release
    a_r12_addr_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> done);

endmodule

bind usb_ls_tx usb_ls_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dp       (dp),
    .dm       (dm),
    .oe       (oe),
    .done     (done),
    .dev_addr (dev_addr)
);

// File: tb/tb_usb_ls_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       hs_req = 1'b0;
    logic       hs_nak = 1'b0;
    logic [3:0] byte_count = 4'd2;
    logic       data_valid = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       data_ready;
    logic [6:0] new_addr = 7'h00;
    logic [7:0] dev_addr;
    logic       dp, dm, oe, busy, done, underrun;

    always #5 clk = ~clk;

    usb_ls_tx dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hs_req(hs_req), .hs_nak(hs_nak),
        .byte_count(byte_count), .data_valid(data_valid), .data_in(data_in),
        .data_ready(data_ready), .new_addr(new_addr), .dev_addr(dev_addr),
        .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done), .underrun(underrun)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [7:0] pkt [0:15];
    logic [1:0] exp_l [0:2047];
    logic [1:0] act_l [0:2047];
    int exp_len, act_len;
    bit pkt_done;
    logic [7:0] exp_addr = 8'h00;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] v, input int n);
        for (int k = 0; k < n; k++) begin
            exp_l[exp_len] = v;
            exp_len++;
        end
    endtask

    // expected {dp,dm} per clock while oe is high (R2..R6, R8)
    task automatic build_exp(input int nbytes);
        logic [1:0] ln;
        int ones;
        exp_len = 0;
        ones = 0;
        ln = 2'b01;
        push(ln, 1);
        for (int i = 0; i < nbytes; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (pkt[i][j]) ones++;
                else begin ln = ~ln; ones = 0; end
                push(ln, 11);
                if (ones == 6) begin ln = ~ln; ones = 0; push(ln, 11); end
            end
        end
        push(2'b00, 22);
        push(2'b01, 11);
    endtask

    function automatic int clamp(input int c);
        if (c < 2) return 2;
        if (c > 12) return 12;
        return c;
    endfunction

    task automatic run_pkt(input int cnt_field, input bit hs, input bit nak,
                           input int avail, input bit mid_start, input string tag);
        int eff, nsend, bad_i, busy_err;
        bit exp_under, ready_seen, prev_oe, first_ok;
        eff = hs ? 2 : clamp(cnt_field);
        pkt[0] = 8'h80;
        if (hs) pkt[1] = nak ? 8'h5A : 8'hD2;
        nsend = hs ? 2 : 1 + ((avail < eff - 1) ? avail : eff - 1);
        exp_under = !hs && (avail < eff - 1);
        build_exp(nsend);
        ready_seen = 0;
        busy_err = 0;
        prev_oe = 0;
        first_ok = 1;
        act_len = 0;
        pkt_done = 0;

        @(negedge clk);
        new_addr = 7'($urandom);
        if (!hs && !exp_under) exp_addr = {new_addr, 1'b0};
        byte_count = 4'(cnt_field);
        hs_req = hs;
        hs_nak = nak;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: one cycle of J with the drivers still off
        first_ok = !oe && !dp && dm;
        check(first_ok, "R2", {tag, " J before enable"}, {dp, dm, oe}, 3'b010);

        fork
            begin : source
                int idx;
                idx = 1;
                while (!pkt_done) begin
                    @(negedge clk);
                    if (hs && data_ready) ready_seen = 1;
                    if (!hs && idx <= avail && idx < eff && !pkt_done) begin
                        data_valid = 1'b1;
                        data_in = pkt[idx];
                        if (data_ready) begin
                            @(posedge clk);
                            #1;
                            data_valid = 1'b0;
                            idx++;
                            repeat ($urandom_range(0, 2)) @(negedge clk);
                        end
                    end else begin
                        data_valid = 1'b0;
                    end
                end
                data_valid = 1'b0;
            end
            begin : capture
                int cyc;
                cyc = 0;
                while (!pkt_done) begin
                    @(negedge clk);
                    cyc++;
                    if (mid_start) begin
                        if (cyc == 150) begin start = 1'b1; byte_count = 4'd3; end
                        else if (cyc == 151) begin start = 1'b0; byte_count = 4'(cnt_field); end
                    end
                    if (busy !== oe) busy_err++;
                    if (oe && act_len < 2048) begin
                        act_l[act_len] = {dp, dm};
                        act_len++;
                    end
                    if (done) begin
                        pkt_done = 1;
                        check(prev_oe && !oe && !dp && !dm, "R8",
                              {tag, " release"}, {prev_oe, oe, dp, dm}, 4'b1000);
                    end
                    prev_oe = oe;
                    if (cyc > 5000) begin
                        pkt_done = 1;
                        check(0, "R8", {tag, " no done"}, cyc, 0);
                    end
                end
            end
        join

        bad_i = -1;
        for (int i = 0; i < exp_len && i < act_len; i++)
            if (bad_i < 0 && act_l[i] !== exp_l[i]) bad_i = i;
        check(act_len == exp_len, "R6", {tag, " packet length"}, act_len, exp_len);
        if (bad_i >= 0)
            check(0, "R5", {tag, " line trace"}, act_l[bad_i], exp_l[bad_i]);
        else
            check(1, "R4", {tag, " line trace"}, 0, 0);
        check(busy_err == 0, "R9", {tag, " busy vs oe"}, busy_err, 0);
        check(underrun == exp_under, "R11", {tag, " underrun"}, underrun, exp_under);
        check(dev_addr == exp_addr, "R12", {tag, " address"}, dev_addr, exp_addr);
        if (hs) check(!ready_seen, "R7", {tag, " no fetch"}, ready_seen, 0);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            check(0, "R1", "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({dp, dm, oe, busy, done, underrun, data_ready} == 7'b0, "R1", "reset outputs",
              {dp, dm, oe, busy, done, underrun, data_ready}, 0);
        check(dev_addr == 8'h00, "R1", "reset address", dev_addr, 0);

        // R3: sync plus one byte
        pkt[1] = 8'hA5;
        run_pkt(2, 0, 0, 1, 0, "R3 min packet");
        // R5: long run of ones across bytes
        for (int i = 1; i < 5; i++) pkt[i] = 8'hFF;
        run_pkt(5, 0, 0, 4, 0, "R5 ones run");
        // R5: run split by a byte boundary
        pkt[1] = 8'hE0; pkt[2] = 8'h07;
        run_pkt(3, 0, 0, 2, 0, "R5 boundary");
        // R5: stuffed bit right before end of packet
        pkt[1] = 8'h12; pkt[2] = 8'hFC;
        run_pkt(3, 0, 0, 2, 0, "R5 tail stuff");
        // R7: handshakes
        run_pkt(2, 1, 0, 0, 0, "R7 ack");
        run_pkt(9, 1, 1, 0, 0, "R7 nak");
        // R3: clamping of byte_count
        pkt[1] = 8'h3C;
        run_pkt(1, 0, 0, 11, 0, "R3 clamp low");
        for (int i = 1; i < 12; i++) pkt[i] = 8'($urandom);
        run_pkt(15, 0, 0, 11, 0, "R3 clamp high");
        // R11: source runs dry
        for (int i = 1; i < 6; i++) pkt[i] = 8'($urandom);
        run_pkt(6, 0, 0, 2, 0, "R11 underrun");
        // R13: request during a packet
        for (int i = 1; i < 8; i++) pkt[i] = 8'($urandom);
        run_pkt(8, 0, 0, 7, 1, "R13 busy start");
        // R4: all zeros, maximum length
        for (int i = 1; i < 12; i++) pkt[i] = 8'h00;
        run_pkt(12, 0, 0, 11, 0, "R4 zeros");

        // R10: random packets
        for (int t = 0; t < 25; t++) begin
            int c;
            bit h;
            c = $urandom_range(2, 12);
            h = ($urandom_range(0, 4) == 0);
            for (int i = 1; i < 12; i++)
                pkt[i] = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
            run_pkt(c, h, 1'($urandom), 11, 0, "R10 random");
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule